// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block converts a logical address, made of a segment choice and a 32-bit offset, into a 32-bit linear address. It keeps six selector registers: code, stack, data and three extra segments. Each selector register has a hidden cache that holds the base of the descriptor it names.

When a selector is written, the block works out where its 8-byte descriptor sits in the global or local descriptor table. It fetches the descriptor as two 32-bit words over a valid/ready read port and keeps the assembled base in the hidden cache. Translations after that add the offset to the cached base and never touch memory. The block also reports the current privilege level and flags translations that go through a null selector.

A core drives one selector load at a time on the load port and translation requests on the translate port. It sees a result one cycle after each accepted request. A request for a segment whose fetch is still in flight is held back until the fetch ends.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `ld_ready` is 1, `rd_valid` is 0, `out_valid` is 0 and `cpl` is 0.
- R2: A selector load with index I and table bit T reads the low descriptor word at (T ? `ldt_base` : `gdt_base`) + 8·I and then the high word at that address + 4. Selector bits: index = [15:3], T = [2], requested privilege = [1:0]. `rd_addr` stays stable while `rd_valid` waits for `rd_ready`.
- R3: The cached base is {high[31:24], high[7:0], low[31:16]}.
- R4: An accepted translation (`xl_valid` and `xl_ready`) sets `out_valid` on the next cycle, with `out_linear` = cached base + `xl_offset`, modulo 2^32.
- R5: Translations issue no memory reads.
- R6: While the fetch for a segment is pending, `xl_ready` is 0 for that segment and 1 for every other segment. After the fetch, a translation of that segment uses the new base.
- R7: A selector with index 0 and T = 0 is null. Loading it issues no reads and sets the cached base to 0. A translation through it returns `out_null` = 1. Index 0 with T = 1 is not null and is fetched.
- R8: `cpl` equals bits [1:0] of the selector in segment 0 (code). It changes on the cycle after that load is accepted.
- R9: `ld_ready` is 0 while a fetch is in progress, so at most one fetch is pending. It returns to 1 on the cycle after the high word is taken.
- R10: Segment codes are 0 code, 1 stack, 2 data, and 3 to 5 extra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Selector load request |
| ld_seg | input | 3 | Segment code to load |
| ld_sel | input | 16 | New selector value |
| ld_ready | output | 1 | Load accepted when high |
| gdt_base | input | 32 | Global table base address |
| ldt_base | input | 32 | Local table base address |
| rd_valid | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_ready | input | 1 | Read accepted; `rd_data` valid |
| rd_data | input | 32 | Descriptor word |
| xl_valid | input | 1 | Translation request |
| xl_seg | input | 3 | Segment code to translate through |
| xl_offset | input | 32 | Offset within the segment |
| xl_ready | output | 1 | Translation accepted when high |
| out_valid | output | 1 | Result valid |
| out_linear | output | 32 | Linear address |
| out_null | output | 1 | Result went through a null selector |
| cpl | output | 2 | Current privilege level |

## Verification
A stale or wrongly assembled cached base shows up as a wrong `out_linear` on the first translation after the load completes, one cycle after acceptance. A wrong table choice or index scaling shows up even earlier, on `rd_addr`, at the first read of the fetch. A lost or stuck pending bit shows at the ports as `xl_ready` being wrong for that segment in the very next cycle, or as a hang. A null decode error shows as an extra read pair or a wrong `out_null` on the next translation.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int SEL_W    = 16;
   localparam int CODE_SEG = 0;

   typedef logic [SEL_W-1:0] selector_t;
   typedef enum logic [1:0] {F_IDLE, F_LOW, F_HIGH} fetch_state_e;

   function automatic logic [12:0] sel_index(selector_t s);
      return s[15:3];
   endfunction

   function automatic logic sel_local(selector_t s);
      return s[2];
   endfunction

   function automatic logic sel_is_null(selector_t s);
      return (s[15:3] == 13'd0) && !s[2];
   endfunction
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
   import seg_xlate_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NUM_SEG = 6,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic [SEG_W-1:0] ld_seg,
   input  selector_t        ld_sel,
   input  logic [AW-1:0]    gdt_base,
   input  logic [AW-1:0]    ldt_base,
   output logic             ld_ready,
   output logic             rd_valid,
   output logic [AW-1:0]    rd_addr,
   input  logic             rd_ready,
   input  logic [31:0]      rd_data,
   output logic             sel_we,
   output logic [SEG_W-1:0] wr_seg,
   output logic             base_we,
   output logic [31:0]      base_val,
   output logic             pend_set,
   output logic             pend_clr
);
   fetch_state_e     st_q;
   logic [SEG_W-1:0] tgt_q;
   logic [AW-1:0]    addr_q;
   logic [15:0]      lo_q;
   logic             take, seg_ok, is_null, hs;
   logic [AW-1:0]    desc_addr;
   logic             unused_bits;

   assign unused_bits = ^{rd_data[15:8], ld_sel[1:0]};

   assign ld_ready  = (st_q == F_IDLE);
   assign seg_ok    = {1'b0, ld_seg} < (SEG_W+1)'(NUM_SEG);
   assign take      = ld_valid && ld_ready && seg_ok;
   assign is_null   = sel_is_null(ld_sel);
   assign desc_addr = (sel_local(ld_sel) ? ldt_base : gdt_base)
                    + AW'({sel_index(ld_sel), 3'b000});
   assign rd_valid  = (st_q != F_IDLE);
   assign rd_addr   = addr_q;
   assign hs        = rd_valid && rd_ready;

   assign sel_we   = take;
   assign pend_set = take && !is_null;
   assign pend_clr = (st_q == F_HIGH) && hs;
   assign base_we  = (take && is_null) || pend_clr;
   assign base_val = pend_clr ? {rd_data[31:24], rd_data[7:0], lo_q} : 32'd0;
   assign wr_seg   = ld_ready ? ld_seg : tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= F_IDLE;
         tgt_q  <= '0;
         addr_q <= '0;
         lo_q   <= '0;
      end else begin
         unique case (st_q)
            F_IDLE: if (take && !is_null) begin
               st_q   <= F_LOW;
               tgt_q  <= ld_seg;
               addr_q <= desc_addr;
            end
            F_LOW: if (hs) begin
               lo_q   <= rd_data[31:16];
               addr_q <= addr_q + AW'(4);
               st_q   <= F_HIGH;
            end
            F_HIGH: if (hs) st_q <= F_IDLE;
            default: st_q <= F_IDLE;
         endcase
      end
   end

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

   // R2
   hi_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == F_LOW && rd_ready) |=> (rd_addr == $past(rd_addr) + AW'(4)));

   // R9
   ld_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == F_HIGH && rd_ready) |=> ld_ready);
endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
   import seg_xlate_pkg::*;
#(
   parameter int NUM_SEG = 6,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sel_we,
   input  logic [SEG_W-1:0]              wr_seg,
   input  selector_t                     sel_in,
   input  logic                          base_we,
   input  logic [31:0]                   base_val,
   input  logic                          pend_set,
   input  logic                          pend_clr,
   output logic [NUM_SEG-1:0][SEL_W-1:0] sel_all,
   output logic [NUM_SEG-1:0][31:0]      base_all,
   output logic [NUM_SEG-1:0]            pend
);
   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      selector_t   sel_q;
      logic [31:0] base_q;
      logic        pend_q;
      logic        hit;

      assign hit = (wr_seg == SEG_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sel_q  <= '0;
            base_q <= '0;
            pend_q <= 1'b0;
         end else begin
            if (sel_we && hit)  sel_q  <= sel_in;
            if (base_we && hit) base_q <= base_val;
            if (pend_set && hit)      pend_q <= 1'b1;
            else if (pend_clr && hit) pend_q <= 1'b0;
         end
      end

      assign sel_all[g]  = sel_q;
      assign base_all[g] = base_q;
      assign pend[g]     = pend_q;
   end

   // R9
   one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend));
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NUM_SEG = 6,
   localparam int SEG_W  = $clog2(NUM_SEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic [SEG_W-1:0] ld_seg,
   input  logic [15:0]      ld_sel,
   output logic             ld_ready,
   input  logic [AW-1:0]    gdt_base,
   input  logic [AW-1:0]    ldt_base,
   output logic             rd_valid,
   output logic [AW-1:0]    rd_addr,
   input  logic             rd_ready,
   input  logic [31:0]      rd_data,
   input  logic             xl_valid,
   input  logic [SEG_W-1:0] xl_seg,
   input  logic [AW-1:0]    xl_offset,
   output logic             xl_ready,
   output logic             out_valid,
   output logic [AW-1:0]    out_linear,
   output logic             out_null,
   output logic [1:0]       cpl
);
   if (AW != 32) begin : g_bad_aw
      $error("seg_xlate_unit: AW must be 32");
   end
   if (NUM_SEG < 2 || NUM_SEG > 8) begin : g_bad_nseg
      $error("seg_xlate_unit: NUM_SEG out of range");
   end

   logic                          sel_we, base_we, pend_set, pend_clr;
   logic [SEG_W-1:0]              wr_seg;
   logic [31:0]                   base_val;
   logic [NUM_SEG-1:0][SEL_W-1:0] sel_all;
   logic [NUM_SEG-1:0][31:0]      base_all;
   logic [NUM_SEG-1:0]            pend;
   selector_t                     cur_sel;
   logic [31:0]                   cur_base;
   logic                          cur_pend, xl_take;

   seg_desc_fetch #(.AW(AW), .NUM_SEG(NUM_SEG)) fetch_i (
      .clk, .rst_n, .ld_valid, .ld_seg, .ld_sel, .gdt_base, .ldt_base,
      .ld_ready, .rd_valid, .rd_addr, .rd_ready, .rd_data,
      .sel_we, .wr_seg, .base_we, .base_val, .pend_set, .pend_clr
   );

   seg_cache_bank #(.NUM_SEG(NUM_SEG)) bank_i (
      .clk, .rst_n, .sel_we, .wr_seg, .sel_in(ld_sel), .base_we, .base_val,
      .pend_set, .pend_clr, .sel_all, .base_all, .pend
   );

   always_comb begin
      cur_sel  = '0;
      cur_base = '0;
      cur_pend = 1'b0;
      for (int i = 0; i < NUM_SEG; i++) begin
         if (xl_seg == SEG_W'(i)) begin
            cur_sel  = sel_all[i];
            cur_base = base_all[i];
            cur_pend = pend[i];
         end
      end
   end

   assign xl_ready = !cur_pend;
   assign xl_take  = xl_valid && xl_ready;
   assign cpl      = sel_all[CODE_SEG][1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_linear <= '0;
         out_null   <= 1'b0;
      end else begin
         out_valid <= xl_take;
         if (xl_take) begin
            out_linear <= cur_base + xl_offset;
            out_null   <= sel_is_null(cur_sel);
         end
      end
   end

   // R4
   out_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(xl_valid && xl_ready));

   // R6
   stall_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_valid && !xl_ready) |=> !out_valid);

   // R8
   cpl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_ready && ld_seg == SEG_W'(CODE_SEG)) |=> (cpl == $past(ld_sel[1:0])));
endmodule

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;
   localparam logic [31:0] GDT = 32'h0010_0000;
   localparam logic [31:0] LDT = 32'h0088_0000;

   logic        clk = 0, rst_n = 0;
   logic        ld_valid = 0, rd_ready = 0, xl_valid = 0;
   logic [2:0]  ld_seg = 0, xl_seg = 0;
   logic [15:0] ld_sel = 0;
   logic [31:0] xl_offset = 0, rd_data;
   logic        ld_ready, rd_valid, xl_ready, out_valid, out_null;
   logic [31:0] rd_addr, out_linear;
   logic [1:0]  cpl;

   int checks = 0, errors = 0, rd_count = 0, mem_lat = 0, wait_cnt = 0;
   logic [31:0] last_addr = 0, prev_addr = 0;

   always #5 clk = ~clk;

   seg_xlate_unit dut_i (
      .clk, .rst_n, .ld_valid, .ld_seg, .ld_sel, .ld_ready,
      .gdt_base(GDT), .ldt_base(LDT), .rd_valid, .rd_addr, .rd_ready, .rd_data,
      .xl_valid, .xl_seg, .xl_offset, .xl_ready, .out_valid, .out_linear,
      .out_null, .cpl
   );

   function automatic logic [31:0] word_at(logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] exp_base(logic [15:0] s);
      logic [31:0] a, lo, hi;
      if (s[15:2] == 14'd0) return 32'd0;
      a  = (s[2] ? LDT : GDT) + {16'd0, s[15:3], 3'b000};
      lo = word_at(a);
      hi = word_at(a + 32'd4);
      return {hi[31:24], hi[7:0], lo[31:16]};
   endfunction

   assign rd_data = word_at(rd_addr);

   always @(negedge clk) begin
      if (rd_ready) begin
         rd_ready = 0;
         wait_cnt = 0;
      end else if (rd_valid) begin
         if (wait_cnt >= mem_lat) rd_ready = 1;
         else wait_cnt++;
      end
   end

   always @(posedge clk) if (rd_valid && rd_ready) begin
      rd_count  <= rd_count + 1;
      prev_addr <= last_addr;
      last_addr <= rd_addr;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_load(logic [2:0] seg, logic [15:0] sel);
      while (!ld_ready) @(negedge clk);
      ld_valid = 1; ld_seg = seg; ld_sel = sel;
      @(negedge clk);
      ld_valid = 0;
   endtask

   task automatic wait_idle();
      while (!ld_ready) @(negedge clk);
   endtask

   task automatic do_xlate(logic [2:0] seg, logic [31:0] off,
                           output logic [31:0] lin, output logic nul);
      xl_valid = 1; xl_seg = seg; xl_offset = off;
      #1;
      while (!xl_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      chk("R4 out_valid", {31'd0, out_valid}, 32'd1);
      lin = out_linear; nul = out_null;
      xl_valid = 0;
   endtask

   task automatic t_reset();
      chk("R1 ld_ready", {31'd0, ld_ready}, 32'd1);
      chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
      chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
      chk("R1 cpl", {30'd0, cpl}, 32'd0);
   endtask

   task automatic t_global_load();
      logic [15:0] s = {13'd5, 1'b0, 2'd0};
      logic [31:0] lin; logic nul; int r0 = rd_count;
      do_load(3'd2, s);
      wait_idle();
      chk("R2 read count", rd_count - r0, 32'd2);
      chk("R2 low addr", prev_addr, GDT + 32'd40);
      chk("R2 high addr", last_addr, GDT + 32'd44);
      do_xlate(3'd2, 32'h0000_1234, lin, nul);
      chk("R3 R4 linear data seg", lin, exp_base(s) + 32'h0000_1234);
      chk("R7 not null", {31'd0, nul}, 32'd0);
   endtask

   task automatic t_local_load();
      logic [15:0] s = {13'h1ABC, 1'b1, 2'd3};
      logic [31:0] lin; logic nul;
      do_load(3'd3, s);
      wait_idle();
      chk("R2 local low addr", prev_addr, LDT + {16'd0, 13'h1ABC, 3'b000});
      do_xlate(3'd3, 32'hFFFF_FFF0, lin, nul);
      chk("R4 R10 wrap linear", lin, exp_base(s) + 32'hFFFF_FFF0);
   endtask

   task automatic t_no_reads();
      logic [31:0] lin; logic nul; int r0 = rd_count;
      for (int k = 0; k < 5; k++) do_xlate(3'd2, 32'(k * 64), lin, nul);
      do_xlate(3'd3, 32'd7, lin, nul);
      chk("R5 no reads on translate", rd_count - r0, 32'd0);
   endtask

   task automatic t_stall();
      logic [15:0] s = {13'd9, 1'b0, 2'd0};
      logic [31:0] lin; logic nul;
      mem_lat = 5;
      do_load(3'd1, s);
      xl_seg = 3'd1; #1;
      chk("R6 stalled seg", {31'd0, xl_ready}, 32'd0);
      chk("R9 ld_ready busy", {31'd0, ld_ready}, 32'd0);
      xl_seg = 3'd2; #1;
      chk("R6 other seg free", {31'd0, xl_ready}, 32'd1);
      do_xlate(3'd1, 32'h0000_0100, lin, nul);
      chk("R6 fresh base", lin, exp_base(s) + 32'h0000_0100);
      mem_lat = 0;
   endtask

   task automatic t_null();
      logic [31:0] lin; logic nul; int r0 = rd_count;
      do_load(3'd4, 16'h0003);
      wait_idle();
      chk("R7 null no reads", rd_count - r0, 32'd0);
      do_xlate(3'd4, 32'h0000_0ABC, lin, nul);
      chk("R7 null flag", {31'd0, nul}, 32'd1);
      chk("R7 null base zero", lin, 32'h0000_0ABC);
      r0 = rd_count;
      do_load(3'd5, 16'h0004);
      wait_idle();
      chk("R7 local index0 fetched", rd_count - r0, 32'd2);
      do_xlate(3'd5, 32'd0, lin, nul);
      chk("R7 local index0 not null", {31'd0, nul}, 32'd0);
   endtask

   task automatic t_cpl();
      do_load(3'd0, {13'd2, 1'b0, 2'd3});
      chk("R8 cpl 3", {30'd0, cpl}, 32'd3);
      wait_idle();
      do_load(3'd0, {13'd3, 1'b0, 2'd1});
      chk("R8 cpl 1", {30'd0, cpl}, 32'd1);
      wait_idle();
      do_load(3'd2, {13'd4, 1'b0, 2'd2});
      wait_idle();
      chk("R8 cpl unaffected by data seg", {30'd0, cpl}, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_global_load();
      t_local_load();
      t_no_reads();
      t_stall();
      t_null();
      t_cpl();
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule